// File: doc/BRIEF.md
# Uncached Load Entry Controller with Per-State Flush

This block controls one slot of a load queue that holds a single uncached load (non-cacheable memory or device register). Once the slot is allocated, the block issues exactly one request to a downstream uncached-access port. It then accepts exactly one response, identified by the slot's id. It holds the returned data and offers it for writeback. When the writeback is accepted, it returns the slot to the free list.

A pipeline redirect can arrive at any time. The redirect carries a circular age tag made of a wrap bit and an index. The slot is squashed when its own age is equal to the redirect age or younger than it. How the squash is carried out depends on the current state.

- Before the request has left, the squash acts in the same cycle.
- After the request has left, the squash is recorded in a pending bit. The slot is cleared only when the matching response handshake completes, so no response is ever left without an owner.
- While the slot waits for writeback, the squash suppresses the writeback in the same cycle.

Every release, for any reason, also clears the pending bit. A stale squash therefore cannot affect the next load placed in the slot.

Top module: `ucld_entry_ctrl`

## Requirements
- R1: After reset the slot is empty: `busy_o`, `req_vld_o`, `wb_vld_o`, `rsp_rdy_o` and `release_o` are all 0.
- R2: An allocation of an empty slot that is not flushed in the same cycle makes `busy_o` 1 and `req_vld_o` 1 in the next cycle.
- R3: Ages are `{wrap, index}`. An entry is flushed by a valid redirect when its age equals the redirect age, or when (wrap bits differ) XOR (entry index > redirect index) is 1. Otherwise the entry is left alone.
- R4: An allocation that meets a flushing redirect in the same cycle is not taken. `release_o` is 1 in that cycle and the slot stays empty.
- R5: In the request state, a flush holds `req_vld_o` at 0, raises `release_o` in the same cycle, and empties the slot. No request handshake can occur in that cycle.
- R6: While a request is outstanding, `release_o` stays 0 until a response with the slot's id is accepted. A live flush in the response-handshake cycle releases the slot in that cycle. One response is accepted for every request handshake.
- R7: A flush seen while a request is outstanding is remembered after the redirect goes away. The matching response then releases the slot, and no writeback is offered.
- R8: In the writeback state, a flush holds `wb_vld_o` at 0 and raises `release_o` in the same cycle.
- R9: With no flush, the response data appears on `wb_data_o` with `wb_vld_o` 1. Both hold until `wb_rdy_i`. `release_o` pulses in the writeback-handshake cycle, and the slot is empty afterwards.
- R10: A response whose id differs from the slot's id is ignored: no release occurs and no writeback is offered.
- R11: A remembered flush is cleared on release, so the next allocated load completes normally.
- R12: After a request handshake, `req_vld_o` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld_i | input | 1 | Allocate this slot |
| alloc_age_i | input | AGE_W+1 | Age of the load being allocated |
| redir_vld_i | input | 1 | Redirect (flush) valid |
| redir_age_i | input | AGE_W+1 | Redirect age; equal or younger entries are flushed |
| req_vld_o | output | 1 | Uncached request valid |
| req_rdy_i | input | 1 | Downstream accepts the request |
| req_id_o | output | ID_W | Slot id sent with the request |
| rsp_vld_i | input | 1 | Response valid |
| rsp_id_i | input | ID_W | Id carried by the response |
| rsp_rdy_o | output | 1 | Slot is waiting for its response |
| rsp_data_i | input | DATA_W | Response data |
| wb_vld_o | output | 1 | Writeback request |
| wb_rdy_i | input | 1 | Writeback slot granted |
| wb_data_o | output | DATA_W | Held load data |
| release_o | output | 1 | One-cycle pulse returning the slot to the free list |
| busy_o | output | 1 | Slot holds a live load |

## Verification
The bench builds the block with AGE_W=3, ID_W=2, DATA_W=16 and ENTRY_ID=2. With only eight index values, ages on both sides of the wrap point are easy to choose, so the wrap-bit comparison can be checked both ways. The 2-bit id leaves room for a foreign response id to show that such a response is ignored. Each of the four states receives a flushing redirect and a non-flushing one. After every load, the bench compares the count of request handshakes with the count of accepted responses.

// File: rtl/ucld_pkg.sv
package ucld_pkg;
  typedef enum logic [1:0] {
    UC_IDLE = 2'd0,
    UC_REQ  = 2'd1,
    UC_RESP = 2'd2,
    UC_WAIT = 2'd3
  } uc_state_e;
endpackage

// File: rtl/ucld_age_cmp.sv
// Circular age comparison: hit when entry is the same age as or younger than the redirect.
module ucld_age_cmp #(
  parameter int unsigned AGE_W = 4
) (
  input  logic [AGE_W:0] ent_age_i,
  input  logic [AGE_W:0] redir_age_i,
  input  logic           redir_vld_i,
  output logic           hit_o
);
  localparam int unsigned IDX_MSB = AGE_W - 1;

  logic wrap_diff;
  logic idx_gt;
  logic same_age;
  logic younger;

  always_comb begin
    wrap_diff = ent_age_i[AGE_W] ^ redir_age_i[AGE_W];
    idx_gt    = ent_age_i[IDX_MSB:0] > redir_age_i[IDX_MSB:0];
    same_age  = ent_age_i == redir_age_i;
    younger   = wrap_diff ^ idx_gt;
    hit_o     = redir_vld_i & (same_age | younger);
  end
endmodule

// File: rtl/ucld_hold.sv
// Enabled holding register with asynchronous active-low reset.
module ucld_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else if (en_i) begin
      q_o <= d_i;
    end
  end
endmodule

// File: rtl/ucld_fsm.sv
// Slot state machine with per-state flush handling and pending-flush bit.
module ucld_fsm
  import ucld_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      alloc_vld_i,
  input  logic      flush_i,
  input  logic      req_rdy_i,
  input  logic      rsp_hit_i,
  input  logic      wb_rdy_i,
  output uc_state_e state_o,
  output logic      pend_o,
  output logic      req_vld_o,
  output logic      rsp_rdy_o,
  output logic      wb_vld_o,
  output logic      release_o,
  output logic      age_en_o,
  output logic      data_en_o
);
  uc_state_e state_q, state_d;
  logic      pend_q, pend_d;

  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    req_vld_o = 1'b0;
    rsp_rdy_o = 1'b0;
    wb_vld_o  = 1'b0;
    release_o = 1'b0;
    age_en_o  = 1'b0;
    data_en_o = 1'b0;
    unique case (state_q)
      UC_IDLE: begin
        if (alloc_vld_i) begin
          if (flush_i) begin
            release_o = 1'b1;
          end else begin
            age_en_o = 1'b1;
            state_d  = UC_REQ;
          end
        end
      end
      UC_REQ: begin
        if (flush_i) begin
          release_o = 1'b1;
          state_d   = UC_IDLE;
        end else begin
          req_vld_o = 1'b1;
          if (req_rdy_i) begin
            state_d = UC_RESP;
          end
        end
      end
      UC_RESP: begin
        rsp_rdy_o = 1'b1;
        if (rsp_hit_i) begin
          if (flush_i || pend_q) begin
            release_o = 1'b1;
            state_d   = UC_IDLE;
          end else begin
            data_en_o = 1'b1;
            state_d   = UC_WAIT;
          end
        end else if (flush_i) begin
          pend_d = 1'b1;
        end
      end
      UC_WAIT: begin
        if (flush_i) begin
          release_o = 1'b1;
          state_d   = UC_IDLE;
        end else begin
          wb_vld_o = 1'b1;
          if (wb_rdy_i) begin
            release_o = 1'b1;
            state_d   = UC_IDLE;
          end
        end
      end
      default: state_d = UC_IDLE;
    endcase
    if (release_o) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UC_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign state_o = state_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/ucld_entry_ctrl.sv
module ucld_entry_ctrl
  import ucld_pkg::*;
#(
  parameter int unsigned AGE_W    = 4,
  parameter int unsigned ID_W     = 4,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned ENTRY_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_vld_i,
  input  logic [AGE_W:0]    alloc_age_i,
  input  logic              redir_vld_i,
  input  logic [AGE_W:0]    redir_age_i,
  output logic              req_vld_o,
  input  logic              req_rdy_i,
  output logic [ID_W-1:0]   req_id_o,
  input  logic              rsp_vld_i,
  input  logic [ID_W-1:0]   rsp_id_i,
  output logic              rsp_rdy_o,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              wb_vld_o,
  input  logic              wb_rdy_i,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              release_o,
  output logic              busy_o
);
  localparam logic [ID_W-1:0] MY_ID = ID_W'(ENTRY_ID);

  uc_state_e      st_w;
  logic           pend_w;
  logic           flush_w;
  logic           rsp_hit_w;
  logic           age_en_w;
  logic           data_en_w;
  logic [AGE_W:0] age_q;
  logic [AGE_W:0] cmp_age_w;

  assign cmp_age_w = (st_w == UC_IDLE) ? alloc_age_i : age_q;
  assign rsp_hit_w = rsp_vld_i && (rsp_id_i == MY_ID);
  assign req_id_o  = MY_ID;
  assign busy_o    = st_w != UC_IDLE;

  ucld_age_cmp #(.AGE_W(AGE_W)) u_cmp (
    .ent_age_i   (cmp_age_w),
    .redir_age_i (redir_age_i),
    .redir_vld_i (redir_vld_i),
    .hit_o       (flush_w)
  );

  ucld_hold #(.W(AGE_W + 1)) u_age (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (age_en_w),
    .d_i   (alloc_age_i),
    .q_o   (age_q)
  );

  ucld_hold #(.W(DATA_W)) u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (data_en_w),
    .d_i   (rsp_data_i),
    .q_o   (wb_data_o)
  );

  ucld_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_vld_i (alloc_vld_i),
    .flush_i     (flush_w),
    .req_rdy_i   (req_rdy_i),
    .rsp_hit_i   (rsp_hit_w),
    .wb_rdy_i    (wb_rdy_i),
    .state_o     (st_w),
    .pend_o      (pend_w),
    .req_vld_o   (req_vld_o),
    .rsp_rdy_o   (rsp_rdy_o),
    .wb_vld_o    (wb_vld_o),
    .release_o   (release_o),
    .age_en_o    (age_en_w),
    .data_en_o   (data_en_w)
  );
endmodule

// File: rtl/ucld_entry_chk.sv
module ucld_entry_chk
  import ucld_pkg::*;
#(
  parameter int unsigned ID_W     = 4,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned ENTRY_ID = 0
) (
  input logic              clk,
  input logic              rst_n,
  input uc_state_e         st_i,
  input logic              pend_i,
  input logic              alloc_vld_i,
  input logic              redir_vld_i,
  input logic              req_vld_i,
  input logic              req_rdy_i,
  input logic              rsp_vld_i,
  input logic [ID_W-1:0]   rsp_id_i,
  input logic              wb_vld_i,
  input logic              wb_rdy_i,
  input logic [DATA_W-1:0] wb_data_i,
  input logic              release_i,
  input logic              busy_i
);
  localparam logic [ID_W-1:0] MY_ID = ID_W'(ENTRY_ID);

  a_r2_alloc_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && alloc_vld_i && !release_i) |=> busy_i);

  a_r5_req_not_with_release: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld_i |-> !release_i);

  a_r6_hold_until_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == UC_RESP && !(rsp_vld_i && rsp_id_i == MY_ID)) |-> !release_i);

  a_r8_wb_wait_no_release: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld_i && !wb_rdy_i) |-> !release_i);

  a_r9_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld_i && !wb_rdy_i && !redir_vld_i) |=> (wb_vld_i && $stable(wb_data_i)));

  a_r11_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> (!pend_i && st_i == UC_IDLE));

  a_r12_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld_i && req_rdy_i) |=> !req_vld_i);
endmodule

bind ucld_entry_ctrl ucld_entry_chk #(
  .ID_W(ID_W), .DATA_W(DATA_W), .ENTRY_ID(ENTRY_ID)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st_i        (st_w),
  .pend_i      (pend_w),
  .alloc_vld_i (alloc_vld_i),
  .redir_vld_i (redir_vld_i),
  .req_vld_i   (req_vld_o),
  .req_rdy_i   (req_rdy_i),
  .rsp_vld_i   (rsp_vld_i),
  .rsp_id_i    (rsp_id_i),
  .wb_vld_i    (wb_vld_o),
  .wb_rdy_i    (wb_rdy_i),
  .wb_data_i   (wb_data_o),
  .release_i   (release_o),
  .busy_i      (busy_o)
);

// File: tb/sim_ucld_entry_ctrl.sv
module sim_ucld_entry_ctrl;
  localparam int unsigned AW  = 3;
  localparam int unsigned IW  = 2;
  localparam int unsigned DW  = 16;
  localparam int unsigned EID = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_vld = 1'b0;
  logic [AW:0]   alloc_age = '0;
  logic          redir_vld = 1'b0;
  logic [AW:0]   redir_age = '0;
  logic          req_vld_o;
  logic          req_rdy = 1'b0;
  logic [IW-1:0] req_id_o;
  logic          rsp_vld = 1'b0;
  logic [IW-1:0] rsp_id = '0;
  logic          rsp_rdy_o;
  logic [DW-1:0] rsp_data = '0;
  logic          wb_vld_o;
  logic          wb_rdy = 1'b0;
  logic [DW-1:0] wb_data_o;
  logic          release_o;
  logic          busy_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_req = 0;
  int n_rsp = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  ucld_entry_ctrl #(.AGE_W(AW), .ID_W(IW), .DATA_W(DW), .ENTRY_ID(EID)) u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld_i(alloc_vld), .alloc_age_i(alloc_age),
    .redir_vld_i(redir_vld), .redir_age_i(redir_age),
    .req_vld_o(req_vld_o), .req_rdy_i(req_rdy), .req_id_o(req_id_o),
    .rsp_vld_i(rsp_vld), .rsp_id_i(rsp_id), .rsp_rdy_o(rsp_rdy_o), .rsp_data_i(rsp_data),
    .wb_vld_o(wb_vld_o), .wb_rdy_i(wb_rdy), .wb_data_o(wb_data_o),
    .release_o(release_o), .busy_o(busy_o)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (req_vld_o && req_rdy) n_req++;
      if (rsp_vld && rsp_rdy_o && rsp_id == IW'(EID)) n_rsp++;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // {phase[2:0], flush_expected, entry_age[3:0], redirect_age[3:0]}
  // phase: 0 none, 1 idle, 2 request, 3 response, 4 writeback
  localparam logic [11:0] VEC [10] = '{
    {3'd0, 1'b0, 4'b0_001, 4'b0_000},
    {3'd1, 1'b1, 4'b0_010, 4'b0_010},  // R3 equal age
    {3'd1, 1'b0, 4'b0_001, 4'b0_100},  // R3 older, not flushed
    {3'd2, 1'b1, 4'b0_101, 4'b0_011},  // R3 younger, same wrap
    {3'd2, 1'b0, 4'b0_001, 4'b0_011},
    {3'd3, 1'b1, 4'b1_001, 4'b0_110},  // R3 younger across wrap
    {3'd3, 1'b0, 4'b0_110, 4'b1_001},  // R11 follows a pending flush
    {3'd4, 1'b1, 4'b0_111, 4'b0_111},
    {3'd4, 1'b0, 4'b1_000, 4'b1_011},
    {3'd0, 1'b0, 4'b1_100, 4'b0_000}
  };

  task automatic run_case(input logic [3:0] e, input logic [3:0] r, input int ph,
                          input bit ex, input logic [DW-1:0] d);
    bit gone = 1'b0;
    @(negedge clk);
    alloc_vld = 1'b1; alloc_age = e;
    if (ph == 1) begin redir_vld = 1'b1; redir_age = r; end
    #1 chk(32'(release_o), 32'(ph == 1 && ex), "R4 idle-flush release");
    @(negedge clk); alloc_vld = 1'b0; redir_vld = 1'b0;
    #1;
    if (ph == 1 && ex) begin
      chk(32'(busy_o), 0, "R4 allocation not taken");
      gone = 1'b1;
    end else begin
      chk(32'(busy_o), 1, "R2 slot busy after allocate");
    end
    if (!gone) begin
      if (ph == 2) begin redir_vld = 1'b1; redir_age = r; end
      req_rdy = 1'b1;
      #1 chk(32'(req_vld_o), 32'(!(ph == 2 && ex)), "R5 request gated by flush");
      chk(32'(release_o), 32'(ph == 2 && ex), "R5 request-state release");
      @(negedge clk); req_rdy = 1'b0; redir_vld = 1'b0;
      #1 chk(32'(req_vld_o), 0, "R12 request dropped after handshake");
      if (ph == 2 && ex) begin
        chk(32'(busy_o), 0, "R5 slot emptied");
        gone = 1'b1;
      end
    end
    if (!gone) begin
      if (ph == 3) begin redir_vld = 1'b1; redir_age = r; end
      #1 chk(32'(release_o), 0, "R6 no early clear while outstanding");
      @(negedge clk); redir_vld = 1'b0;
      @(negedge clk); rsp_vld = 1'b1; rsp_id = IW'(EID); rsp_data = d;
      #1 chk(32'(release_o), 32'(ph == 3 && ex), "R7 pending flush applied at response");
      @(negedge clk); rsp_vld = 1'b0;
      #1 chk(32'(wb_vld_o), 32'(!(ph == 3 && ex)), "R7 writeback suppressed");
      if (ph == 3 && ex) begin
        chk(32'(busy_o), 0, "R7 slot emptied");
        gone = 1'b1;
      end
    end
    if (!gone) begin
      chk(32'(wb_data_o), 32'(d), "R9 response data held");
      if (ph == 4) begin redir_vld = 1'b1; redir_age = r; end
      wb_rdy = 1'b1;
      #1 chk(32'(wb_vld_o), 32'(!(ph == 4 && ex)), "R8 writeback gated by flush");
      chk(32'(release_o), 1, "R9 release on writeback or flush");
      @(negedge clk); wb_rdy = 1'b0; redir_vld = 1'b0;
      #1 chk(32'(busy_o), 0, "R9 slot empty after release");
    end
    chk(32'(n_req), 32'(n_rsp), "R6 one response per request");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(32'(busy_o), 0, "R1 reset busy");
    chk(32'(req_vld_o), 0, "R1 reset request");
    chk(32'(wb_vld_o), 0, "R1 reset writeback");
    chk(32'(rsp_rdy_o), 0, "R1 reset response ready");
    chk(32'(release_o), 0, "R1 reset release");
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      run_case(VEC[i][7:4], VEC[i][3:0], int'(VEC[i][11:9]), VEC[i][8], DW'(16'hA500 + i));
    end

    // R10: foreign response id ignored; then R6 live flush at response cycle
    @(negedge clk); alloc_vld = 1'b1; alloc_age = 4'b0_011;
    @(negedge clk); alloc_vld = 1'b0; req_rdy = 1'b1;
    @(negedge clk); req_rdy = 1'b0;
    rsp_vld = 1'b1; rsp_id = 2'd1; rsp_data = 16'hDEAD;
    #1 chk(32'(release_o), 0, "R10 foreign response ignored");
    @(negedge clk); rsp_vld = 1'b0;
    #1 chk(32'(wb_vld_o), 0, "R10 no writeback from foreign response");
    chk(32'(busy_o), 1, "R10 slot still waiting");
    @(negedge clk); rsp_vld = 1'b1; rsp_id = IW'(EID); redir_vld = 1'b1; redir_age = 4'b0_011;
    #1 chk(32'(release_o), 1, "R6 live flush at response handshake");
    @(negedge clk); rsp_vld = 1'b0; redir_vld = 1'b0;
    #1 chk(32'(busy_o), 0, "R6 slot emptied after flushed response");
    chk(32'(wb_vld_o), 0, "R6 no writeback after flushed response");
    chk(32'(n_req), 32'(n_rsp), "R6 one response per request");

    // R11: next load after a live-flushed response completes normally
    run_case(4'b0_010, 4'b0_000, 0, 1'b0, 16'h1234);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule